// File: doc/BRIEF.md
# Floating-Point Operand Unpacker and Classifier

This block turns a memory operand into the wide working form that a floating-point datapath computes on. The operand is up to three 32-bit words plus a format code. The code selects a signed integer (8, 16 or 32 bits), a 32-bit or 64-bit binary float, or a 96-bit extended float whose integer bit is stored explicitly. The result is the following, after one register stage:

- a sign;
- an unbiased two's-complement exponent;
- a 64-bit mantissa whose leading one sits at bit 63 for every finite nonzero value;
- a sticky bit, always cleared;
- a class code.

Denormal floats and integers are normalized with a leading-zero count. Signalling NaNs are made quiet on entry, but they keep a class of their own and set a sticky status flag that stays high until it is explicitly cleared. A format code that is not supported gives a defined error class and an illegal-format indication.

An upstream load path puts the operand words and the format code on the inputs together with `in_valid`. The unpacked result appears one cycle later, qualified by `out_valid`.

Top module: `fpu_unpack`

## Requirements
- R1: Format codes are 0 long (32-bit integer), 1 single, 2 extended, 4 word (16-bit integer), 5 double, 6 byte (8-bit integer). Codes 3 and 7 give class 7 (error) with `out_illegal`=1 and sign, exponent and mantissa all zero. Legal codes give `out_illegal`=0.
- R2: For every legal format, `out_sign` equals bit 31 of `in_w0`, and `out_sticky` is always 0.
- R3: The integer value is taken as two's complement from `in_w0[31:24]` (byte), `in_w0[31:16]` (word) or the whole of `in_w0` (long), sign-extended. Zero gives class 0 (zero). Any other value gives class 1 (number), with the magnitude normalized to `out_mant[63]`=1 and the exponent equal to the bit index of the magnitude's leading one.
- R4: A single operand uses exponent field `in_w0[30:23]` (bias 127) and fraction `in_w0[22:0]`. A double uses field `in_w0[30:20]` (bias 1023) and fraction `{in_w0[19:0], in_w1}`. For a normal value the exponent is the field minus the bias, `out_mant[63]` is 1, the fraction sits directly below it and the lower bits are zero.
- R5: A single or double with a zero field and a nonzero fraction starts at exponent 1 minus the bias, without an implied one. It is then left-shifted until `out_mant[63]`=1, and the exponent drops by the shift count.
- R6: An extended operand has exponent field `in_w0[30:16]` (bias 16383) and mantissa `{in_w1, in_w2}` with the integer bit at bit 63. For a field other than 0 and all-ones, the exponent is the field minus 16383 and bit 63 is forced to 1.
- R7: An extended operand with a zero field and a nonzero mantissa starts at exponent -16383 and is normalized as in R5. With a zero mantissa it is class zero.
- R8: Class zero (0) and infinity (2) report exponent 0 and mantissa 0. An all-ones field with a zero fraction gives infinity. For extended operands the fraction here means all 64 bits of `{in_w1, in_w2}`.
- R9: An all-ones field with a nonzero fraction is a NaN. The fraction is copied without an implied one, left-aligned below bit 63 for single and double, and as `{in_w1, in_w2}` for extended. The exponent is 0. If `out_mant[62]` (the quiet bit) is set, the class is 3 (quiet NaN).
- R10: A NaN with its quiet bit clear comes out with `out_mant[62]` set and class 4 (signalling NaN).
- R11: `snan_flag` is set on the clock edge that loads a class-4 result and stays set until `clr_snan` is sampled high. If both happen on the same edge, set wins.
- R12: With `REG_OUT`=1 the result appears on the edge after `in_valid`, and `out_valid` is high for exactly one cycle. The result registers hold while `in_valid` is low. After reset `out_valid` and `snan_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand words and format code are valid |
| in_fmt | input | 3 | Format code (R1) |
| in_w0 | input | 32 | First operand word (sign, exponent, high fraction, integers) |
| in_w1 | input | 32 | Second operand word |
| in_w2 | input | 32 | Third operand word (extended only) |
| clr_snan | input | 1 | Clears the sticky signalling-NaN flag |
| out_valid | output | 1 | Result valid |
| out_sign | output | 1 | Sign of the result |
| out_exp | output | EXP_W | Unbiased signed exponent |
| out_mant | output | 64 | Left-aligned mantissa |
| out_sticky | output | 1 | Sticky bit, always 0 |
| out_class | output | 3 | Class: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN, 7 error |
| out_illegal | output | 1 | Format code not supported |
| snan_flag | output | 1 | Sticky signalling-NaN status |

## Verification
The hardest cases to reach are the widest normalization shifts: a lone fraction bit at the very bottom of a double, or of an extended operand whose exponent field is zero. These need the full leading-zero count and exponents close to the most negative value. The stimulus builds them directly as single-bit operand words (fraction LSB only), so the expected shift of 52 or 63 is known exactly. The sticky flag is also checked in the same cycle as a clear request, by presenting a signalling NaN while `clr_snan` is high.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;

   localparam int MANT_W = 64;
   localparam int QBIT   = MANT_W - 2;

   typedef enum logic [2:0] {
      FMT_LONG   = 3'd0,
      FMT_SINGLE = 3'd1,
      FMT_EXT    = 3'd2,
      FMT_WORD   = 3'd4,
      FMT_DOUBLE = 3'd5,
      FMT_BYTE   = 3'd6
   } fmt_e;

   typedef enum logic [2:0] {
      CLS_ZERO = 3'd0,
      CLS_NUM  = 3'd1,
      CLS_INF  = 3'd2,
      CLS_QNAN = 3'd3,
      CLS_SNAN = 3'd4,
      CLS_ERR  = 3'd7
   } class_e;

endpackage

// File: rtl/fpu_unpack_int.sv
module fpu_unpack_int
   import fpu_unpack_pkg::*;
#(
   parameter int EXP_W = 18
)(
   input  logic [31:0]          w0,
   input  fmt_e                 fmt,
   output class_e               cls,
   output logic [EXP_W-1:0]     exp_o,
   output logic [MANT_W-1:0]    mant_o
);
   localparam int IW = 32;

   logic [IW-1:0] ival;
   logic [IW-1:0] mag;

   always_comb begin
      case (fmt)
         FMT_BYTE: ival = {{(IW-8){w0[31]}}, w0[31:24]};
         FMT_WORD: ival = {{(IW-16){w0[31]}}, w0[31:16]};
         default:  ival = w0;
      endcase
      mag = ival[IW-1] ? (~ival + 1'b1) : ival;
   end

   // magnitude top bit sits at MANT_W-1, so exponent starts at IW-1
   assign cls    = (mag == '0) ? CLS_ZERO : CLS_NUM;
   assign exp_o  = (mag == '0) ? '0 : EXP_W'(IW - 1);
   assign mant_o = {mag, {(MANT_W-IW){1'b0}}};

endmodule

// File: rtl/fpu_unpack_flt.sv
module fpu_unpack_flt
   import fpu_unpack_pkg::*;
#(
   parameter int EBITS        = 8,
   parameter int FBITS        = 23,
   parameter bit EXPLICIT_INT = 1'b0,
   parameter int EXP_W        = 18
)(
   input  logic [EBITS-1:0]     exp_fld,
   input  logic [FBITS-1:0]     frac_fld,
   output class_e               cls,
   output logic [EXP_W-1:0]     exp_o,
   output logic [MANT_W-1:0]    mant_o,
   output logic                 norm_o
);
   localparam int BIAS  = (1 << (EBITS - 1)) - 1;
   localparam int DEN_E = EXPLICIT_INT ? -BIAS : 1 - BIAS;

   logic [MANT_W-1:0] mant_raw;

   if (EXPLICIT_INT) begin : g_explicit
      if (FBITS != MANT_W) begin : g_bad_w
         $error("explicit-integer format needs FBITS == MANT_W");
      end
      assign mant_raw = frac_fld;
   end else begin : g_hidden
      if (FBITS > MANT_W - 2) begin : g_bad_w
         $error("hidden-one format needs FBITS <= MANT_W-2");
      end
      assign mant_raw = {1'b0, frac_fld, {(MANT_W-1-FBITS){1'b0}}};
   end

   logic frac_nz;
   logic fld_zero;
   logic fld_ones;

   assign frac_nz  = |frac_fld;
   assign fld_zero = (exp_fld == '0);
   assign fld_ones = &exp_fld;

   always_comb begin
      cls    = CLS_NUM;
      exp_o  = '0;
      mant_o = '0;
      norm_o = 1'b0;
      if (fld_zero) begin
         if (frac_nz) begin
            exp_o  = EXP_W'(DEN_E);
            mant_o = mant_raw;
            norm_o = 1'b1;
         end else begin
            cls = CLS_ZERO;
         end
      end else if (fld_ones) begin
         if (frac_nz) begin
            cls    = CLS_QNAN;
            mant_o = mant_raw;
         end else begin
            cls = CLS_INF;
         end
      end else begin
         exp_o  = EXP_W'(int'(exp_fld) - BIAS);
         mant_o = {1'b1, mant_raw[MANT_W-2:0]};
      end
   end

endmodule

// File: rtl/fpu_unpack_norm.sv
module fpu_unpack_norm #(
   parameter int W     = 64,
   parameter int EXP_W = 18
)(
   input  logic [W-1:0]         mant_i,
   input  logic [EXP_W-1:0]     exp_i,
   input  logic                 en,
   output logic [W-1:0]         mant_o,
   output logic [EXP_W-1:0]     exp_o
);
   localparam int CW = $clog2(W) + 1;

   logic [CW-1:0] lz;

   always_comb begin
      lz = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (mant_i[i]) lz = CW'(W - 1 - i);
      end
   end

   always_comb begin
      if (en && lz < CW'(W)) begin
         mant_o = mant_i << lz;
         exp_o  = exp_i - EXP_W'(lz);
      end else begin
         mant_o = mant_i;
         exp_o  = exp_i;
      end
   end

endmodule

// File: rtl/fpu_unpack.sv
module fpu_unpack
   import fpu_unpack_pkg::*;
#(
   parameter int EXP_W   = 18,
   parameter bit REG_OUT = 1'b1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [2:0]           in_fmt,
   input  logic [31:0]          in_w0,
   input  logic [31:0]          in_w1,
   input  logic [31:0]          in_w2,
   input  logic                 clr_snan,
   output logic                 out_valid,
   output logic                 out_sign,
   output logic [EXP_W-1:0]     out_exp,
   output logic [MANT_W-1:0]    out_mant,
   output logic                 out_sticky,
   output logic [2:0]           out_class,
   output logic                 out_illegal,
   output logic                 snan_flag
);
   if (EXP_W < 18) begin : g_bad_exp
      $error("EXP_W must hold the extended range (>= 18 bits)");
   end

   fmt_e fmt;
   assign fmt = fmt_e'(in_fmt);

   // ---------------- format-specific front ends ----------------
   class_e            i_cls, s_cls, d_cls, x_cls;
   logic [EXP_W-1:0]  i_exp, s_exp, d_exp, x_exp;
   logic [MANT_W-1:0] i_mant, s_mant, d_mant, x_mant;
   logic              s_norm, d_norm, x_norm;

   fpu_unpack_int #(.EXP_W(EXP_W)) u_int (
      .w0(in_w0), .fmt(fmt), .cls(i_cls), .exp_o(i_exp), .mant_o(i_mant)
   );

   fpu_unpack_flt #(.EBITS(8), .FBITS(23), .EXPLICIT_INT(1'b0), .EXP_W(EXP_W)) u_sgl (
      .exp_fld(in_w0[30:23]), .frac_fld(in_w0[22:0]),
      .cls(s_cls), .exp_o(s_exp), .mant_o(s_mant), .norm_o(s_norm)
   );

   fpu_unpack_flt #(.EBITS(11), .FBITS(52), .EXPLICIT_INT(1'b0), .EXP_W(EXP_W)) u_dbl (
      .exp_fld(in_w0[30:20]), .frac_fld({in_w0[19:0], in_w1}),
      .cls(d_cls), .exp_o(d_exp), .mant_o(d_mant), .norm_o(d_norm)
   );

   fpu_unpack_flt #(.EBITS(15), .FBITS(64), .EXPLICIT_INT(1'b1), .EXP_W(EXP_W)) u_ext (
      .exp_fld(in_w0[30:16]), .frac_fld({in_w1, in_w2}),
      .cls(x_cls), .exp_o(x_exp), .mant_o(x_mant), .norm_o(x_norm)
   );

   // ---------------- format select ----------------
   class_e            sel_cls;
   logic [EXP_W-1:0]  sel_exp;
   logic [MANT_W-1:0] sel_mant;
   logic              sel_norm;
   logic              sel_ill;

   always_comb begin
      sel_cls  = CLS_ERR;
      sel_exp  = '0;
      sel_mant = '0;
      sel_norm = 1'b0;
      sel_ill  = 1'b0;
      case (fmt)
         FMT_LONG, FMT_WORD, FMT_BYTE: begin
            sel_cls  = i_cls;
            sel_exp  = i_exp;
            sel_mant = i_mant;
            sel_norm = (i_cls == CLS_NUM);
         end
         FMT_SINGLE: begin
            sel_cls = s_cls; sel_exp = s_exp; sel_mant = s_mant; sel_norm = s_norm;
         end
         FMT_DOUBLE: begin
            sel_cls = d_cls; sel_exp = d_exp; sel_mant = d_mant; sel_norm = d_norm;
         end
         FMT_EXT: begin
            sel_cls = x_cls; sel_exp = x_exp; sel_mant = x_mant; sel_norm = x_norm;
         end
         default: sel_ill = 1'b1;
      endcase
   end

   // ---------------- NaN quieting ----------------
   class_e            q_cls;
   logic [MANT_W-1:0] q_mant;

   always_comb begin
      q_cls  = sel_cls;
      q_mant = sel_mant;
      if (sel_cls == CLS_QNAN && !sel_mant[QBIT]) begin
         q_cls        = CLS_SNAN;
         q_mant[QBIT] = 1'b1;
      end
   end

   // ---------------- normalization ----------------
   logic [MANT_W-1:0] n_mant;
   logic [EXP_W-1:0]  n_exp;

   fpu_unpack_norm #(.W(MANT_W), .EXP_W(EXP_W)) u_norm (
      .mant_i(q_mant), .exp_i(sel_exp), .en(sel_norm),
      .mant_o(n_mant), .exp_o(n_exp)
   );

   logic nxt_sign;
   assign nxt_sign = sel_ill ? 1'b0 : in_w0[31];

   // ---------------- sticky status ----------------
   logic snan_set;
   assign snan_set = in_valid && (q_cls == CLS_SNAN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        snan_flag <= 1'b0;
      else if (snan_set) snan_flag <= 1'b1;
      else if (clr_snan) snan_flag <= 1'b0;
   end

   assign out_sticky = 1'b0;

   // ---------------- output stage ----------------
   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid   <= 1'b0;
            out_sign    <= 1'b0;
            out_exp     <= '0;
            out_mant    <= '0;
            out_class   <= CLS_ZERO;
            out_illegal <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               out_sign    <= nxt_sign;
               out_exp     <= n_exp;
               out_mant    <= n_mant;
               out_class   <= q_cls;
               out_illegal <= sel_ill;
            end
         end
      end

      // R11: a signalling-NaN result is accompanied by the raised flag
      assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && out_class == CLS_SNAN) |-> snan_flag)
         else $error("assert_snan_flag_follows_R11");
   end else begin : g_comb
      assign out_valid   = in_valid;
      assign out_sign    = nxt_sign;
      assign out_exp     = n_exp;
      assign out_mant    = n_mant;
      assign out_class   = q_cls;
      assign out_illegal = sel_ill;
   end

   // ---------------- assertions ----------------
   assert_num_normalized_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_class == CLS_NUM) |-> out_mant[MANT_W-1]);

   assert_nan_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_class == CLS_QNAN || out_class == CLS_SNAN)) |-> out_mant[QBIT]);

   assert_empty_mant_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_class == CLS_ZERO || out_class == CLS_INF)) |-> (out_mant == '0));

   assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (snan_flag && !clr_snan) |=> snan_flag);

   assert_illegal_class_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_illegal) |-> (out_class == CLS_ERR && out_mant == '0));

endmodule

// File: tb/fpu_unpack_bench.sv
module fpu_unpack_bench;
   localparam int CLK_PERIOD = 10;
   localparam int EW = 18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_fmt = 3'd0;
   logic [31:0] in_w0 = '0, in_w1 = '0, in_w2 = '0;
   logic        clr_snan = 1'b0;
   logic        out_valid, out_sign, out_sticky, out_illegal, snan_flag;
   logic [EW-1:0] out_exp;
   logic [63:0] out_mant;
   logic [2:0]  out_class;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpu_unpack #(.EXP_W(EW), .REG_OUT(1'b1)) u_fpu_unpack (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fmt(in_fmt),
      .in_w0(in_w0), .in_w1(in_w1), .in_w2(in_w2), .clr_snan(clr_snan),
      .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
      .out_mant(out_mant), .out_sticky(out_sticky), .out_class(out_class),
      .out_illegal(out_illegal), .snan_flag(snan_flag)
   );

   task automatic check_bit(input string req, input logic act, input logic exp_v);
      total++;
      if (act !== exp_v) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b", req, act, exp_v);
      end
   endtask

   // one operand in, sampled one negedge later (one register stage)
   task automatic apply(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] c);
      @(negedge clk);
      in_fmt = f; in_w0 = a; in_w1 = b; in_w2 = c; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic expect_res(input string req, input logic s, input int e,
                             input logic [63:0] m, input logic [2:0] cl, input logic ill);
      int ae;
      ae = int'($signed(out_exp));
      total++;
      if (out_valid !== 1'b1 || out_sign !== s || ae != e || out_mant !== m ||
          out_class !== cl || out_illegal !== ill || out_sticky !== 1'b0) begin
         bad++;
         $display("FAIL %s: actual v=%0b s=%0b e=%0d m=%h c=%0d ill=%0b st=%0b expected v=1 s=%0b e=%0d m=%h c=%0d ill=%0b st=0",
                  req, out_valid, out_sign, ae, out_mant, out_class, out_illegal, out_sticky,
                  s, e, m, cl, ill);
      end
   endtask

   localparam logic [63:0] TOP = 64'h8000_0000_0000_0000;

   task automatic t_reset();
      check_bit("R12 reset out_valid", out_valid, 1'b0);
      check_bit("R12 reset snan_flag", snan_flag, 1'b0);
   endtask

   task automatic t_integers();
      apply(3'd0, 32'h0000_0001, 0, 0); expect_res("R3 long 1", 0, 0, TOP, 3'd1, 0);
      apply(3'd0, 32'hFFFF_FFFF, 0, 0); expect_res("R3 long -1 R2 sign", 1, 0, TOP, 3'd1, 0);
      apply(3'd0, 32'h8000_0000, 0, 0); expect_res("R3 long min", 1, 31, TOP, 3'd1, 0);
      apply(3'd6, 32'hFD00_0000, 0, 0); expect_res("R3 byte -3", 1, 1, 64'hC000_0000_0000_0000, 3'd1, 0);
      apply(3'd4, 32'h0005_1234, 0, 0); expect_res("R3 word 5", 0, 2, 64'hA000_0000_0000_0000, 3'd1, 0);
      apply(3'd6, 32'h00FF_FFFF, 0, 0); expect_res("R3 byte zero", 0, 0, 64'h0, 3'd0, 0);
      apply(3'd0, 32'h0000_0000, 0, 0); expect_res("R3 long zero R8", 0, 0, 64'h0, 3'd0, 0);
   endtask

   task automatic t_single();
      apply(3'd1, 32'h3F80_0000, 0, 0); expect_res("R4 single 1.0", 0, 0, TOP, 3'd1, 0);
      apply(3'd1, 32'hBFC0_0000, 0, 0); expect_res("R4 single -1.5", 1, 0, 64'hC000_0000_0000_0000, 3'd1, 0);
      apply(3'd1, 32'h0000_0001, 0, 0); expect_res("R5 single min denormal", 0, -149, TOP, 3'd1, 0);
      apply(3'd1, 32'h7F80_0000, 0, 0); expect_res("R8 single inf", 0, 0, 64'h0, 3'd2, 0);
      apply(3'd1, 32'h7FC0_0001, 0, 0); expect_res("R9 single qnan", 0, 0, 64'h4000_0100_0000_0000, 3'd3, 0);
      check_bit("R11 flag stays low on qnan", snan_flag, 1'b0);
   endtask

   task automatic t_double();
      apply(3'd5, 32'h3FF0_0000, 32'h0, 0); expect_res("R4 double 1.0", 0, 0, TOP, 3'd1, 0);
      apply(3'd5, 32'h4004_0000, 32'h0, 0); expect_res("R4 double 2.5", 0, 1, 64'hA000_0000_0000_0000, 3'd1, 0);
      apply(3'd5, 32'h0000_0000, 32'h1, 0); expect_res("R5 double min denormal", 0, -1074, TOP, 3'd1, 0);
      apply(3'd5, 32'h8000_0000, 32'h0, 0); expect_res("R8 double -0", 1, 0, 64'h0, 3'd0, 0);
   endtask

   task automatic t_extended();
      apply(3'd2, 32'h3FFF_0000, 32'h8000_0000, 0); expect_res("R6 ext 1.0", 0, 0, TOP, 3'd1, 0);
      apply(3'd2, 32'h4000_0000, 32'h4000_0000, 0); expect_res("R6 ext forced int bit", 0, 1, 64'hC000_0000_0000_0000, 3'd1, 0);
      apply(3'd2, 32'h0000_0000, 32'h0, 32'h1); expect_res("R7 ext deep denormal", 0, -16446, TOP, 3'd1, 0);
      apply(3'd2, 32'h0000_0000, 32'h8000_0000, 0); expect_res("R7 ext zero field explicit one", 0, -16383, TOP, 3'd1, 0);
      apply(3'd2, 32'h8000_0000, 32'h0, 32'h0); expect_res("R7 ext signed zero", 1, 0, 64'h0, 3'd0, 0);
      apply(3'd2, 32'h7FFF_0000, 32'h0, 32'h0); expect_res("R8 ext inf", 0, 0, 64'h0, 3'd2, 0);
      apply(3'd2, 32'hFFFF_0000, 32'hC000_0000, 0); expect_res("R9 ext qnan", 1, 0, 64'hC000_0000_0000_0000, 3'd3, 0);
   endtask

   task automatic t_snan();
      apply(3'd1, 32'h7F80_0001, 0, 0); expect_res("R10 single snan", 0, 0, 64'h4000_0100_0000_0000, 3'd4, 0);
      check_bit("R11 flag set by snan", snan_flag, 1'b1);
      apply(3'd1, 32'h3F80_0000, 0, 0);
      check_bit("R11 flag holds", snan_flag, 1'b1);
      @(negedge clk); clr_snan = 1'b1;
      @(negedge clk); clr_snan = 1'b0;
      check_bit("R11 flag cleared", snan_flag, 1'b0);
      @(negedge clk);
      in_fmt = 3'd5; in_w0 = 32'h7FF0_0000; in_w1 = 32'h1; in_valid = 1'b1; clr_snan = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; clr_snan = 1'b0;
      expect_res("R10 double snan", 0, 0, 64'h4000_0000_0000_0800, 3'd4, 0);
      check_bit("R11 set wins over clear", snan_flag, 1'b1);
   endtask

   task automatic t_illegal();
      apply(3'd3, 32'hFFFF_FFFF, 32'h1, 32'h1); expect_res("R1 code 3", 0, 0, 64'h0, 3'd7, 1);
      apply(3'd7, 32'h8000_0000, 0, 0); expect_res("R1 code 7", 0, 0, 64'h0, 3'd7, 1);
   endtask

   task automatic t_idle();
      apply(3'd0, 32'h0000_0003, 0, 0); expect_res("R12 before idle", 0, 1, 64'hC000_0000_0000_0000, 3'd1, 0);
      @(negedge clk);
      check_bit("R12 out_valid single cycle", out_valid, 1'b0);
      total++;
      if (out_mant !== 64'hC000_0000_0000_0000) begin
         bad++;
         $display("FAIL R12 hold: actual=%h expected=%h", out_mant, 64'hC000_0000_0000_0000);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_integers();
      t_single();
      t_double();
      t_extended();
      t_snan();
      t_illegal();
      t_idle();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule